// File: doc/BRIEF.md
# PCM Sample Playback Engine

This block plays signed PCM audio from a byte-wide sample queue. Software programs a control register that sets volume, channel layout and sample width. It sets a rate register that paces playback, then streams bytes into a data register. The bytes land in an on-chip queue. A phase-accumulator tick pulls one complete frame (one or two channels, one or two bytes per channel) out of the queue. The frame is scaled by the 4-bit volume and driven onto two 16-bit signed outputs, with a one-cycle strobe for each new frame.

The frame engine is a small state machine. `ST_IDLE` waits for a rate tick while the queue holds at least one whole frame, and on that tick it goes to `ST_TAKE_L_LO` and latches the width and channel layout. `ST_TAKE_L_LO` moves to `ST_TAKE_L_HI` for 16-bit frames, to `ST_TAKE_R_LO` for 8-bit stereo, and to `ST_PRESENT` for 8-bit mono. `ST_TAKE_L_HI` moves to `ST_TAKE_R_LO` for stereo and to `ST_PRESENT` otherwise. `ST_TAKE_R_LO` moves to `ST_TAKE_R_HI` for 16-bit frames and to `ST_PRESENT` otherwise. `ST_TAKE_R_HI` always moves to `ST_PRESENT`. `ST_PRESENT` updates the outputs and returns to `ST_IDLE`. A pending queue flush sends any state straight back to `ST_IDLE`. Each `ST_TAKE_*` state removes one byte from the queue.

Software reads status from the control register. Reads are combinational from the address. Data-register writes are dropped silently when the queue is full.

Top module: `pcm_playback`

## Requirements
- R1: After reset the control register reads 0x40 (queue empty, volume 0, mono, 8-bit), the rate register reads 0, both outputs are 0 and the strobe is low.
- R2: Address 0 is the control register. On write, bits 3:0 are the volume, bit 4 selects stereo (1) or mono (0), and bit 5 selects 16-bit (1) or 8-bit (0) samples. A read returns the same bits in the same positions.
- R3: Control bit 6 reads 1 exactly when the queue is empty, and bit 7 reads 1 exactly when it holds 2**DEPTH_LOG2 bytes. Writing bit 6 has no effect.
- R4: A write to address 2 appends one byte to the queue. A write while the queue is full is discarded without any indication.
- R5: Writing control bit 7 as 1 empties the queue on the clock cycle after the write. The status read in the cycle right after the write edge still shows the old contents.
- R6: Address 1 holds an 8-bit rate value that is added to a 16-bit phase accumulator every clock. Each carry-out paces one frame, so strobes are 65536/rate clocks apart (512 for rate 128). Rate 0 produces no strobes.
- R7: An 8-bit sample is a signed byte placed in the upper byte of the 16-bit sample, with the lower byte zero.
- R8: A 16-bit sample is two bytes, least significant byte first.
- R9: A stereo frame is taken left channel first, then right. In mono the single sample drives both outputs.
- R10: Each output equals floor(sample × volume / 16), using the volume current when the frame is presented.
- R11: If the queue holds less than one whole frame when a tick arrives, nothing is consumed, no strobe occurs and both outputs hold their previous values.
- R12: The rate register reads back the value written. Reads of addresses 2 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write enable for the current cycle |
| bus_addr | input | 2 | Register address: 0 control, 1 rate, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| left_out | output | 16 | Left channel, signed, scaled |
| right_out | output | 16 | Right channel, signed, scaled |
| sample_strobe | output | 1 | One-cycle pulse when new output values appear |

## Verification
The bound checker watches these rules on every cycle:
- the strobe is a single-cycle pulse;
- outputs never move without a strobe;
- mono frames give equal channels;
- a zero rate never ticks;
- a flush write empties the queue two edges later;
- a full queue stays full when written;
- full and empty are never both set;
- a byte is never taken from an empty queue.

The bench's scenarios cover the rest:
- the exact sample arithmetic for each width and layout, including floor rounding of negative products;
- little-endian assembly and left-then-right order;
- the 512-cycle spacing at rate 128;
- a partial frame stalling until its last byte arrives;
- that a byte written to a full queue never reaches the outputs.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    localparam int SAMPLE_W = 16;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_RATE = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

    // Field order matches control bits 5:0
    typedef struct packed {
        logic       wide;
        logic       stereo;
        logic [3:0] volume;
    } pcm_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAKE_L_LO,
        ST_TAKE_L_HI,
        ST_TAKE_R_LO,
        ST_TAKE_R_HI,
        ST_PRESENT
    } frame_state_t;

    // floor(sample * vol / 16)
    function automatic logic [SAMPLE_W-1:0] scale_sample(
        input logic signed [SAMPLE_W-1:0] smp,
        input logic [3:0]                 vol
    );
        logic signed [SAMPLE_W+4:0] prod;
        prod = smp * $signed({1'b0, vol});
        return prod[SAMPLE_W+3:4];
    endfunction

endpackage

// File: rtl/pcm_regs.sv
module pcm_regs
    import pcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    output logic [BYTE_W-1:0] bus_rdata,
    output pcm_mode_t         mode,
    output logic [BYTE_W-1:0] rate,
    output logic              push,
    output logic [BYTE_W-1:0] push_data,
    output logic              flush
);

    pcm_mode_t         mode_q;
    logic [BYTE_W-1:0] rate_q;
    logic              flush_q;
    logic              ctrl_wr;
    logic              rate_wr;

    assign ctrl_wr = bus_wr_en && (bus_addr == ADDR_CTRL);
    assign rate_wr = bus_wr_en && (bus_addr == ADDR_RATE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            rate_q  <= '0;
            flush_q <= 1'b0;
        end else begin
            flush_q <= ctrl_wr && bus_wdata[7];
            if (ctrl_wr) begin
                mode_q <= pcm_mode_t'(bus_wdata[5:0]);
            end
            if (rate_wr) begin
                rate_q <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = {fifo_full, fifo_empty, mode_q};
            ADDR_RATE: bus_rdata = rate_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign push      = bus_wr_en && (bus_addr == ADDR_DATA);
    assign push_data = bus_wdata;
    assign mode      = mode_q;
    assign rate      = rate_q;
    assign flush     = flush_q;

endmodule

// File: rtl/pcm_fifo.sv
module pcm_fifo
    import pcm_pkg::*;
#(
    parameter int DEPTH_LOG2 = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  push,
    input  logic [BYTE_W-1:0]     push_data,
    input  logic                  pop,
    output logic [BYTE_W-1:0]     pop_data,
    output logic [DEPTH_LOG2:0]   level,
    output logic                  full,
    output logic                  empty
);

    localparam int DEPTH = 1 << DEPTH_LOG2;

    logic [BYTE_W-1:0]     mem [DEPTH];
    logic [DEPTH_LOG2-1:0] wr_ptr_q;
    logic [DEPTH_LOG2-1:0] rd_ptr_q;
    logic [DEPTH_LOG2:0]   level_q;
    logic                  do_push;
    logic                  do_pop;

    assign full    = (level_q == (DEPTH_LOG2+1)'(DEPTH));
    assign empty   = (level_q == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr_q <= wr_ptr_q + 1'b1;
            end
            if (do_pop) begin
                rd_ptr_q <= rd_ptr_q + 1'b1;
            end
            if (do_push && !do_pop) begin
                level_q <= level_q + 1'b1;
            end else if (do_pop && !do_push) begin
                level_q <= level_q - 1'b1;
            end
        end
    end

    assign pop_data = mem[rd_ptr_q];
    assign level    = level_q;

endmodule

// File: rtl/pcm_rate_gen.sv
module pcm_rate_gen #(
    parameter int ACC_W  = 16,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;
    logic             tick_q;

    assign sum = {1'b0, acc_q} + (ACC_W+1)'(rate);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= sum[ACC_W-1:0];
            tick_q <= sum[ACC_W];
        end
    end

    assign tick = tick_q;

endmodule

// File: rtl/pcm_frame_fsm.sv
module pcm_frame_fsm
    import pcm_pkg::*;
#(
    parameter int LEVEL_W = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                flush,
    input  pcm_mode_t           mode,
    input  logic [LEVEL_W-1:0]  level,
    input  logic [BYTE_W-1:0]   pop_data,
    output logic                pop,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                sample_strobe,
    output logic                frame_stereo
);

    localparam int SLOTS = 4;

    frame_state_t      state_q;
    frame_state_t      state_d;
    logic              frame_wide_q;
    logic              frame_stereo_q;
    logic [BYTE_W-1:0] slot_q [SLOTS];
    logic [1:0]        take_slot;
    logic [2:0]        need_bytes;
    logic              start;
    logic [SAMPLE_W-1:0] left_raw;
    logic [SAMPLE_W-1:0] right_raw;

    assign need_bytes = 3'd1 << ({1'b0, mode.wide} + {1'b0, mode.stereo});
    assign start      = (state_q == ST_IDLE) && tick && (level >= LEVEL_W'(need_bytes));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      if (start) state_d = ST_TAKE_L_LO;
                ST_TAKE_L_LO: state_d = frame_wide_q ? ST_TAKE_L_HI
                                      : (frame_stereo_q ? ST_TAKE_R_LO : ST_PRESENT);
                ST_TAKE_L_HI: state_d = frame_stereo_q ? ST_TAKE_R_LO : ST_PRESENT;
                ST_TAKE_R_LO: state_d = frame_wide_q ? ST_TAKE_R_HI : ST_PRESENT;
                ST_TAKE_R_HI: state_d = ST_PRESENT;
                ST_PRESENT:   state_d = ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        pop       = 1'b0;
        take_slot = 2'd0;
        unique case (state_q)
            ST_TAKE_L_LO: begin pop = !flush; take_slot = 2'd0; end
            ST_TAKE_L_HI: begin pop = !flush; take_slot = 2'd1; end
            ST_TAKE_R_LO: begin pop = !flush; take_slot = 2'd2; end
            ST_TAKE_R_HI: begin pop = !flush; take_slot = 2'd3; end
            default:      begin pop = 1'b0;   take_slot = 2'd0; end
        endcase
    end

    always_comb begin
        left_raw  = frame_wide_q ? {slot_q[1], slot_q[0]} : {slot_q[0], 8'h00};
        right_raw = left_raw;
        if (frame_stereo_q) begin
            right_raw = frame_wide_q ? {slot_q[3], slot_q[2]} : {slot_q[2], 8'h00};
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_wide_q   <= 1'b0;
            frame_stereo_q <= 1'b0;
            left_out       <= '0;
            right_out      <= '0;
            sample_strobe  <= 1'b0;
            for (int i = 0; i < SLOTS; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            sample_strobe <= 1'b0;
            if (start && !flush) begin
                frame_wide_q   <= mode.wide;
                frame_stereo_q <= mode.stereo;
            end
            if (pop) begin
                slot_q[take_slot] <= pop_data;
            end
            if ((state_q == ST_PRESENT) && !flush) begin
                left_out      <= scale_sample(left_raw, mode.volume);
                right_out     <= scale_sample(right_raw, mode.volume);
                sample_strobe <= 1'b1;
            end
        end
    end

    assign frame_stereo = frame_stereo_q;

endmodule

// File: rtl/pcm_playback.sv
module pcm_playback
    import pcm_pkg::*;
#(
    parameter int DEPTH_LOG2 = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr_en,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic [15:0] left_out,
    output logic [15:0] right_out,
    output logic        sample_strobe
);

    localparam int LEVEL_W = DEPTH_LOG2 + 1;

    pcm_mode_t          mode;
    logic [BYTE_W-1:0]  rate_val;
    logic               fifo_push;
    logic [BYTE_W-1:0]  push_data;
    logic               fifo_flush;
    logic               fifo_pop;
    logic [BYTE_W-1:0]  pop_data;
    logic [LEVEL_W-1:0] fifo_level;
    logic               fifo_full;
    logic               fifo_empty;
    logic               rate_tick;
    logic               frame_stereo;

    pcm_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr_en  (bus_wr_en),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .bus_rdata  (bus_rdata),
        .mode       (mode),
        .rate       (rate_val),
        .push       (fifo_push),
        .push_data  (push_data),
        .flush      (fifo_flush)
    );

    pcm_fifo #(.DEPTH_LOG2(DEPTH_LOG2)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (fifo_flush),
        .push      (fifo_push),
        .push_data (push_data),
        .pop       (fifo_pop),
        .pop_data  (pop_data),
        .level     (fifo_level),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    pcm_rate_gen #(.ACC_W(16), .RATE_W(BYTE_W)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .rate  (rate_val),
        .tick  (rate_tick)
    );

    pcm_frame_fsm #(.LEVEL_W(LEVEL_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (rate_tick),
        .flush         (fifo_flush),
        .mode          (mode),
        .level         (fifo_level),
        .pop_data      (pop_data),
        .pop           (fifo_pop),
        .left_out      (left_out),
        .right_out     (right_out),
        .sample_strobe (sample_strobe),
        .frame_stereo  (frame_stereo)
    );

endmodule

// File: rtl/pcm_playback_chk.sv
module pcm_playback_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr_en,
    input logic [1:0]  bus_addr,
    input logic        wdata_msb,
    input logic        fifo_full,
    input logic        fifo_empty,
    input logic        fifo_push,
    input logic        fifo_pop,
    input logic        fifo_flush,
    input logic [7:0]  rate_val,
    input logic        rate_tick,
    input logic        frame_stereo,
    input logic [15:0] left_out,
    input logic [15:0] right_out,
    input logic        sample_strobe
);

    p_status_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && fifo_push && !fifo_pop && !fifo_flush) |=> fifo_full);

    p_flush_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == 2'd0 && wdata_msb) |-> ##2 fifo_empty);

    p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> !sample_strobe);

    p_rate_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_val == 8'd0) |=> !rate_tick);

    p_mono_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_strobe && !frame_stereo) |-> (left_out == right_out));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_strobe |-> ($stable(left_out) && $stable(right_out)));

    p_pop_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

endmodule

bind pcm_playback pcm_playback_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr_en     (bus_wr_en),
    .bus_addr      (bus_addr),
    .wdata_msb     (bus_wdata[7]),
    .fifo_full     (fifo_full),
    .fifo_empty    (fifo_empty),
    .fifo_push     (fifo_push),
    .fifo_pop      (fifo_pop),
    .fifo_flush    (fifo_flush),
    .rate_val      (rate_val),
    .rate_tick     (rate_tick),
    .frame_stereo  (frame_stereo),
    .left_out      (left_out),
    .right_out     (right_out),
    .sample_strobe (sample_strobe)
);

// File: tb/pcm_playback_bench.sv
module pcm_playback_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr_en;
    logic [1:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [15:0] left_out;
    logic [15:0] right_out;
    logic        sample_strobe;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    pcm_playback #(.DEPTH_LOG2(6)) u_pcm_playback (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr_en     (bus_wr_en),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .left_out      (left_out),
        .right_out     (right_out),
        .sample_strobe (sample_strobe)
    );

    function automatic logic [15:0] scaled(input logic [15:0] raw, input int vol);
        logic signed [15:0] s;
        int p;
        s = raw;
        p = s * vol;
        p = p >>> 4;
        return p[15:0];
    endfunction

    task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_strobe(input int maxc, output bit found, output int cyc);
        found = 1'b0;
        cyc   = 0;
        while (cyc < maxc && !found) begin
            @(negedge clk);
            cyc++;
            if (sample_strobe) found = 1'b1;
        end
    endtask

    task automatic flush_fifo();
        bus_write(2'd0, 8'h80);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_read(2'd0, d);
        check("R1 ctrl after reset", d, 8'h40);
        bus_read(2'd1, d);
        check("R1 rate after reset", d, 8'h00);
        check("R1 left after reset", left_out, 16'h0);
        check("R1 right after reset", right_out, 16'h0);
        check("R1 strobe after reset", sample_strobe, 1'b0);
    endtask

    task automatic t_registers();
        logic [7:0] d;
        bus_write(2'd0, 8'h3A);
        bus_read(2'd0, d);
        check("R2 ctrl fields readback", d, 8'h7A);
        bus_write(2'd2, 8'h11);
        bus_write(2'd0, 8'h45);
        bus_read(2'd0, d);
        check("R3 bit6 write ignored, not empty", d, 8'h05);
        flush_fifo();
        bus_write(2'd1, 8'h80);
        bus_read(2'd1, d);
        check("R12 rate readback", d, 8'h80);
        bus_read(2'd2, d);
        check("R12 data addr reads 0", d, 8'h00);
        bus_read(2'd3, d);
        check("R12 addr3 reads 0", d, 8'h00);
        bus_write(2'd1, 8'h00);
    endtask

    task automatic t_flush();
        logic [7:0] d;
        bus_write(2'd2, 8'h01);
        bus_write(2'd2, 8'h02);
        bus_read(2'd0, d);
        check("R5 not empty before flush", d[6], 1'b0);
        bus_write(2'd0, 8'h80);
        bus_read(2'd0, d);
        check("R5 flush not yet applied", d[6], 1'b0);
        @(negedge clk);
        bus_read(2'd0, d);
        check("R5 empty one cycle later", d, 8'h40);
    endtask

    task automatic t_mono8();
        bit found;
        int cyc;
        flush_fifo();
        bus_write(2'd0, 8'h0F);
        bus_write(2'd2, 8'h40);
        bus_write(2'd2, 8'h80);
        bus_write(2'd1, 8'h80);
        wait_strobe(2000, found, cyc);
        check("R6 first strobe seen", found, 1'b1);
        check("R7 R10 mono8 left", left_out, 16'h3C00);
        check("R9 mono8 right copy", right_out, 16'h3C00);
        wait_strobe(2000, found, cyc);
        check("R6 strobe spacing rate 128", cyc, 512);
        check("R7 negative byte", left_out, 16'h8800);
        wait_strobe(1500, found, cyc);
        check("R11 no strobe on empty queue", found, 1'b0);
        check("R11 left held", left_out, 16'h8800);
        check("R11 right held", right_out, 16'h8800);
        bus_write(2'd1, 8'h00);
    endtask

    task automatic t_rate_zero();
        bit found;
        int cyc;
        bus_write(2'd2, 8'h10);
        wait_strobe(1500, found, cyc);
        check("R6 rate 0 gives no strobe", found, 1'b0);
        check("R6 outputs held at rate 0", left_out, 16'h8800);
        bus_write(2'd1, 8'hFF);
        wait_strobe(1000, found, cyc);
        check("R6 strobe after rate set", found, 1'b1);
        check("R10 volume 15 byte 0x10", left_out, 16'h0F00);
        bus_write(2'd1, 8'h00);
    endtask

    task automatic t_stereo16();
        bit found;
        int cyc;
        flush_fifo();
        bus_write(2'd0, 8'h38);
        bus_write(2'd2, 8'h34);
        bus_write(2'd2, 8'h12);
        bus_write(2'd2, 8'h00);
        bus_write(2'd2, 8'hF0);
        bus_write(2'd2, 8'hFF);
        bus_write(2'd2, 8'h7F);
        bus_write(2'd2, 8'h00);
        bus_write(2'd2, 8'h80);
        bus_write(2'd1, 8'h80);
        wait_strobe(2000, found, cyc);
        check("R8 R9 stereo16 left", left_out, 16'h091A);
        check("R9 stereo16 right", right_out, 16'hF800);
        wait_strobe(2000, found, cyc);
        check("R10 stereo16 max positive", left_out, 16'h3FFF);
        check("R10 stereo16 max negative", right_out, 16'hC000);
        bus_write(2'd1, 8'h00);
    endtask

    task automatic t_mono16();
        bit found;
        int cyc;
        flush_fifo();
        bus_write(2'd0, 8'h21);
        bus_write(2'd2, 8'hFF);
        bus_write(2'd2, 8'hFF);
        bus_write(2'd2, 8'h00);
        bus_write(2'd2, 8'h01);
        bus_write(2'd1, 8'hFF);
        wait_strobe(1000, found, cyc);
        check("R10 floor of -1/16", left_out, 16'hFFFF);
        check("R9 mono16 right copy", right_out, 16'hFFFF);
        wait_strobe(1000, found, cyc);
        check("R8 mono16 little-endian", left_out, 16'h0010);
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h20);
        bus_write(2'd2, 8'h00);
        bus_write(2'd2, 8'h40);
        bus_write(2'd1, 8'hFF);
        wait_strobe(1000, found, cyc);
        check("R10 volume 0 gives zero", left_out, 16'h0000);
        bus_write(2'd1, 8'h00);
    endtask

    task automatic t_stereo8();
        bit found;
        int cyc;
        flush_fifo();
        bus_write(2'd0, 8'h14);
        bus_write(2'd2, 8'h10);
        bus_write(2'd2, 8'hF0);
        bus_write(2'd1, 8'hFF);
        wait_strobe(1000, found, cyc);
        check("R7 R9 stereo8 left", left_out, 16'h0400);
        check("R7 R9 stereo8 right", right_out, 16'hFC00);
        bus_write(2'd1, 8'h00);
    endtask

    task automatic t_partial();
        bit found;
        int cyc;
        flush_fifo();
        bus_write(2'd0, 8'h38);
        bus_write(2'd2, 8'h11);
        bus_write(2'd2, 8'h22);
        bus_write(2'd2, 8'h33);
        bus_write(2'd1, 8'hFF);
        wait_strobe(800, found, cyc);
        check("R11 partial frame waits", found, 1'b0);
        check("R11 left held on partial", left_out, 16'h0400);
        check("R11 right held on partial", right_out, 16'hFC00);
        bus_write(2'd2, 8'h44);
        wait_strobe(1000, found, cyc);
        check("R11 frame plays once complete", left_out, 16'h1108);
        check("R11 right of completed frame", right_out, 16'h2219);
        bus_write(2'd1, 8'h00);
    endtask

    task automatic t_full();
        logic [7:0] d;
        bit found;
        int cyc;
        flush_fifo();
        bus_write(2'd0, 8'h0F);
        for (int i = 0; i < 64; i++) begin
            bus_write(2'd2, i[7:0]);
        end
        bus_read(2'd0, d);
        check("R3 full flag at capacity", d, 8'h8F);
        bus_write(2'd2, 8'h55);
        bus_read(2'd0, d);
        check("R4 extra write no indication", d, 8'h8F);
        bus_write(2'd1, 8'hFF);
        for (int i = 0; i < 64; i++) begin
            wait_strobe(600, found, cyc);
            check("R4 drained byte", left_out, scaled({i[7:0], 8'h00}, 15));
        end
        wait_strobe(800, found, cyc);
        check("R4 dropped byte never plays", found, 1'b0);
        bus_read(2'd0, d);
        check("R3 empty after drain", d, 8'h4F);
        bus_write(2'd1, 8'h00);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R1 got=timeout exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        bus_wr_en = 1'b0;
        bus_addr  = 2'd0;
        bus_wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_registers();
        t_flush();
        t_mono8();
        t_rate_zero();
        t_stereo16();
        t_mono16();
        t_stereo8();
        t_partial();
        t_full();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule